// File: doc/BRIEF.md
# Transmit Port ECC Error Interrupt Collector

This block gathers error events from the transmit buffers of up to four ports. Each port has a store-and-forward buffer and a reorder buffer, and the ECC checker on each buffer reports correctable and uncorrectable events. Each port also reports two other faults: a reorder failure and a packet-assembly failure. Every event arrives as a one-cycle pulse. The block records each event in two places, and software clears the two places separately:
- a shared status register, with one byte lane per port, which feeds the interrupt;
- per-buffer ECC status registers, which keep the kind of ECC fault until software wipes the whole register.

A shared mask register decides which status bits may raise the single aggregated interrupt line. Each port also has two error-injection control words. The block holds these words and drives them to the ECC datapath outside this block.

Software reaches the registers over a plain 64-bit register bus. A write takes effect at the clock edge where `reg_wr_i` is high. Read data is combinational from `reg_addr_i` and needs no strobe. The bus has no valid/ready handshake and never applies back-pressure: every access completes in the cycle it is presented. The event inputs are plain pulses and are never stalled.

Top module: `txp_err_irq_ctrl`

## Requirements
- R1: After reset the following registers read zero: status, all ECC status registers and all injection words. The mask register reads 0x3F in each port lane, so every source is masked. `irq_o` is low.
- R2: An event pulse for port p sets status bit 8·p+k at the next clock edge. The source index k is 0 for store-and-forward correctable, 1 for store-and-forward uncorrectable, 2 for reorder correctable, 3 for reorder uncorrectable, 4 for reorder failure and 5 for packet-assembly failure.
- R3: A mask bit of 1 keeps the matching status bit from raising `irq_o`. A write to the mask register stores only the six source bits of each port lane.
- R4: Writing 1 to a status bit clears that bit. Status bits written with 0, including the bits of other ports' lanes, keep their value.
- R5: If an event pulse arrives in the same cycle as a write-one-to-clear of its status bit, the bit stays set.
- R6: `irq_o` is registered. It is high in the cycle after any cycle in which some status bit is set while its mask bit is 0. An unmasked event therefore raises `irq_o` two edges after its pulse.
- R7: In each buffer's ECC status register, bit 17 latches a correctable event and bit 16 latches an uncorrectable event. Store-and-forward events go to the store-and-forward register and reorder events go to the reorder register. A write with bit 31 at 0 leaves the register unchanged.
- R8: A write with bit 31 at 1 clears the whole ECC status register, so the next read returns zero. An ECC event in the same cycle as the clear is still latched.
- R9: Each injection word stores the low 18 bits of a write and reads back with bits 63:18 at zero. It drives its port's 18-bit slice of `sf_inj_o` or `ro_inj_o`.
- R10: Address map:
  - status at 0x000 and mask at 0x008;
  - port p's registers start at 0x100 + 0x100·p: store-and-forward ECC status at +0x00, reorder ECC status at +0x08, store-and-forward injection at +0x10, reorder injection at +0x18.
  
  Writes to any other address change nothing, and reads of any other address return zero.
- R11: `reg_rdata_o` follows `reg_addr_i` combinationally. It shows the addressed register's contents as of the latest clock edge, with no read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (12) | Byte address of the register access |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for `reg_addr_i` |
| sf_ce_i | input | NUM_PORTS (4) | Store-and-forward correctable ECC event, one per port |
| sf_ue_i | input | NUM_PORTS (4) | Store-and-forward uncorrectable ECC event, one per port |
| ro_ce_i | input | NUM_PORTS (4) | Reorder correctable ECC event, one per port |
| ro_ue_i | input | NUM_PORTS (4) | Reorder uncorrectable ECC event, one per port |
| ro_fail_i | input | NUM_PORTS (4) | Reorder failure event, one per port |
| asm_dead_i | input | NUM_PORTS (4) | Packet-assembly failure event, one per port |
| sf_inj_o | output | NUM_PORTS·18 (72) | Store-and-forward injection words, port p at bits 18·p upward |
| ro_inj_o | output | NUM_PORTS·18 (72) | Reorder injection words, port p at bits 18·p upward |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
An event pulse and a software clear of the same state can land in the same cycle. This happens both for write-one-to-clear on a status lane and for the bit-31 wipe of an ECC status register. The bench provokes each case by driving the pulse in exactly the cycle in which the clearing write is presented. It then judges the result by reading the register on the following cycles: the event's bit must remain set, while every other bit in the cleared set must be zero. A behavioural model is compared with read data, the injection buses and the interrupt on every clock, so a wrong priority shows up at once.

// File: rtl/txp_eirq_pkg.sv
package txp_eirq_pkg;

  localparam int DATA_W = 64;
  localparam int SRC_N  = 6;   // sources per port lane
  localparam int LANE_W = 8;   // lane pitch in the shared registers
  localparam int INJ_W  = 18;

  // source position inside a lane (decoded by software)
  localparam int SRC_SF_CE    = 0;
  localparam int SRC_SF_UE    = 1;
  localparam int SRC_RO_CE    = 2;
  localparam int SRC_RO_UE    = 3;
  localparam int SRC_RO_FAIL  = 4;
  localparam int SRC_ASM_DEAD = 5;

  localparam int ECC_UE_POS  = 16;
  localparam int ECC_CE_POS  = 17;
  localparam int ECC_CLR_POS = 31;

  localparam int OFS_STATUS  = 'h000;
  localparam int OFS_MASK    = 'h008;
  localparam int PORT_BASE   = 'h100;
  localparam int PORT_STRIDE = 'h100;
  localparam int SLOT_SPAN   = 8;
  localparam int SLOT_N      = 4;

  typedef enum logic [1:0] {
    SLOT_SF_ECC = 2'd0,
    SLOT_RO_ECC = 2'd1,
    SLOT_SF_INJ = 2'd2,
    SLOT_RO_INJ = 2'd3
  } slot_e;

  function automatic logic [DATA_W-1:0] lane_field_mask(int nports);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int p = 0; p < nports; p++) m[p*LANE_W +: SRC_N] = '1;
    return m;
  endfunction

endpackage

// File: rtl/txp_eirq_ecc_reg.sv
module txp_eirq_ecc_reg
  import txp_eirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              ce_i,
  input  logic              ue_i,
  output logic [DATA_W-1:0] rd_o
);

  logic ce_q, ue_q;

  // a same-cycle event survives the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b0;
      ue_q <= 1'b0;
    end else begin
      ce_q <= (ce_q & ~clr_i) | ce_i;
      ue_q <= (ue_q & ~clr_i) | ue_i;
    end
  end

  always_comb begin
    rd_o             = '0;
    rd_o[ECC_CE_POS] = ce_q;
    rd_o[ECC_UE_POS] = ue_q;
  end

endmodule

// File: rtl/txp_eirq_port_bank.sv
module txp_eirq_port_bank
  import txp_eirq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [SLOT_N-1:0]              wr_slot_i,
  input  logic                           clr_bit_i,
  input  logic [INJ_W-1:0]               inj_data_i,
  input  logic                           sf_ce_i,
  input  logic                           sf_ue_i,
  input  logic                           ro_ce_i,
  input  logic                           ro_ue_i,
  output logic [SLOT_N-1:0][DATA_W-1:0]  slot_rd_o,
  output logic [INJ_W-1:0]               sf_inj_o,
  output logic [INJ_W-1:0]               ro_inj_o
);

  logic [1:0][INJ_W-1:0] inj_q;

  txp_eirq_ecc_reg u_sf_ecc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (wr_slot_i[SLOT_SF_ECC] & clr_bit_i),
    .ce_i  (sf_ce_i),
    .ue_i  (sf_ue_i),
    .rd_o  (slot_rd_o[SLOT_SF_ECC])
  );

  txp_eirq_ecc_reg u_ro_ecc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (wr_slot_i[SLOT_RO_ECC] & clr_bit_i),
    .ce_i  (ro_ce_i),
    .ue_i  (ro_ue_i),
    .rd_o  (slot_rd_o[SLOT_RO_ECC])
  );

  for (genvar g = 0; g < 2; g++) begin : g_inj
    localparam int SLOT = int'(SLOT_SF_INJ) + g;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              inj_q[g] <= '0;
      else if (wr_slot_i[SLOT]) inj_q[g] <= inj_data_i;
    end
    assign slot_rd_o[SLOT] = DATA_W'(inj_q[g]);
  end

  assign sf_inj_o = inj_q[0];
  assign ro_inj_o = inj_q[1];

endmodule

// File: rtl/txp_eirq_shared.sv
module txp_eirq_shared
  import txp_eirq_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            stat_wr_i,
  input  logic                            mask_wr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [NUM_PORTS-1:0][SRC_N-1:0] evt_i,
  output logic [DATA_W-1:0]               stat_o,
  output logic [DATA_W-1:0]               mask_o,
  output logic                            irq_o
);

  localparam logic [DATA_W-1:0] FIELD_M = lane_field_mask(NUM_PORTS);

  logic [DATA_W-1:0] stat_q, mask_q, evt_wide, w1c;
  logic              irq_q;

  always_comb begin
    evt_wide = '0;
    for (int p = 0; p < NUM_PORTS; p++) evt_wide[p*LANE_W +: SRC_N] = evt_i[p];
  end

  assign w1c = stat_wr_i ? (wdata_i & FIELD_M) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= FIELD_M;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~w1c) | evt_wide;
      if (mask_wr_i) mask_q <= wdata_i & FIELD_M;
      irq_q  <= |(stat_q & ~mask_q);
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/txp_err_irq_ctrl.sv
module txp_err_irq_ctrl
  import txp_eirq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  output logic [DATA_W-1:0]          reg_rdata_o,
  input  logic [NUM_PORTS-1:0]       sf_ce_i,
  input  logic [NUM_PORTS-1:0]       sf_ue_i,
  input  logic [NUM_PORTS-1:0]       ro_ce_i,
  input  logic [NUM_PORTS-1:0]       ro_ue_i,
  input  logic [NUM_PORTS-1:0]       ro_fail_i,
  input  logic [NUM_PORTS-1:0]       asm_dead_i,
  output logic [NUM_PORTS*INJ_W-1:0] sf_inj_o,
  output logic [NUM_PORTS*INJ_W-1:0] ro_inj_o,
  output logic                       irq_o
);

  logic                                        stat_hit, mask_hit;
  logic [NUM_PORTS-1:0][SLOT_N-1:0]            slot_hit;
  logic [NUM_PORTS-1:0][SRC_N-1:0]             evt_w;
  logic [DATA_W-1:0]                           stat_w, mask_w;
  logic [NUM_PORTS-1:0][SLOT_N-1:0][DATA_W-1:0] bank_rd;

  assign stat_hit = (reg_addr_i == ADDR_W'(OFS_STATUS));
  assign mask_hit = (reg_addr_i == ADDR_W'(OFS_MASK));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
      assign slot_hit[p][s] =
        (reg_addr_i == ADDR_W'(PORT_BASE + p*PORT_STRIDE + s*SLOT_SPAN));
    end

    assign evt_w[p] = {asm_dead_i[p], ro_fail_i[p], ro_ue_i[p],
                       ro_ce_i[p], sf_ue_i[p], sf_ce_i[p]};

    txp_eirq_port_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_slot_i  (reg_wr_i ? slot_hit[p] : '0),
      .clr_bit_i  (reg_wdata_i[ECC_CLR_POS]),
      .inj_data_i (reg_wdata_i[INJ_W-1:0]),
      .sf_ce_i    (sf_ce_i[p]),
      .sf_ue_i    (sf_ue_i[p]),
      .ro_ce_i    (ro_ce_i[p]),
      .ro_ue_i    (ro_ue_i[p]),
      .slot_rd_o  (bank_rd[p]),
      .sf_inj_o   (sf_inj_o[p*INJ_W +: INJ_W]),
      .ro_inj_o   (ro_inj_o[p*INJ_W +: INJ_W])
    );
  end

  txp_eirq_shared #(.NUM_PORTS(NUM_PORTS)) u_shared (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_wr_i (reg_wr_i & stat_hit),
    .mask_wr_i (reg_wr_i & mask_hit),
    .wdata_i   (reg_wdata_i),
    .evt_i     (evt_w),
    .stat_o    (stat_w),
    .mask_o    (mask_w),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (stat_hit) reg_rdata_o = stat_w;
    if (mask_hit) reg_rdata_o = mask_w;
    for (int p = 0; p < NUM_PORTS; p++)
      for (int s = 0; s < SLOT_N; s++)
        if (slot_hit[p][s]) reg_rdata_o = bank_rd[p][s];
  end

endmodule

// File: rtl/txp_err_irq_ctrl_chk.sv
module txp_err_irq_ctrl_chk
  import txp_eirq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 12
) (
  input logic                                         clk,
  input logic                                         rst_n,
  input logic                                         reg_wr_i,
  input logic [ADDR_W-1:0]                            reg_addr_i,
  input logic [DATA_W-1:0]                            reg_wdata_i,
  input logic [NUM_PORTS-1:0]                         sf_ce_i,
  input logic [NUM_PORTS-1:0]                         sf_ue_i,
  input logic [NUM_PORTS-1:0]                         ro_ce_i,
  input logic [NUM_PORTS-1:0]                         ro_ue_i,
  input logic [NUM_PORTS-1:0]                         ro_fail_i,
  input logic [NUM_PORTS-1:0]                         asm_dead_i,
  input logic                                         irq_o,
  input logic [DATA_W-1:0]                            stat_w,
  input logic [DATA_W-1:0]                            mask_w,
  input logic [NUM_PORTS-1:0][SLOT_N-1:0][DATA_W-1:0] bank_rd
);

  logic any_evt;
  assign any_evt = |{sf_ce_i, sf_ue_i, ro_ce_i, ro_ue_i, ro_fail_i, asm_dead_i};

  // R4: no write and no event leaves the status register unchanged
  p_quiet_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_i && !any_evt) |=> $stable(stat_w));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    localparam int L = p*LANE_W;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_SFE  = ADDR_W'(PORT_BASE + p*PORT_STRIDE);

    p_evt_sets_stat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      asm_dead_i[p] |=> stat_w[L + SRC_ASM_DEAD]);

    p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == A_STAT && reg_wdata_i[L + SRC_SF_CE] && !sf_ce_i[p])
      |=> !stat_w[L + SRC_SF_CE]);

    p_evt_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == A_STAT && reg_wdata_i[L + SRC_SF_UE] && sf_ue_i[p])
      |=> stat_w[L + SRC_SF_UE]);

    p_unmasked_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_ce_i[p] && !mask_w[L + SRC_SF_CE] && !reg_wr_i) |=> ##1 irq_o);

    p_ecc_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ro_ue_i[p] |=> bank_rd[p][SLOT_RO_ECC][ECC_UE_POS]);

    p_ecc_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == A_SFE && reg_wdata_i[ECC_CLR_POS]
        && !sf_ce_i[p] && !sf_ue_i[p])
      |=> (bank_rd[p][SLOT_SF_ECC] == '0));
  end

endmodule

bind txp_err_irq_ctrl txp_err_irq_ctrl_chk #(
  .NUM_PORTS (NUM_PORTS),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .sf_ce_i     (sf_ce_i),
  .sf_ue_i     (sf_ue_i),
  .ro_ce_i     (ro_ce_i),
  .ro_ue_i     (ro_ue_i),
  .ro_fail_i   (ro_fail_i),
  .asm_dead_i  (asm_dead_i),
  .irq_o       (irq_o),
  .stat_w      (stat_w),
  .mask_w      (mask_w),
  .bank_rd     (bank_rd)
);

// File: tb/txp_err_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module txp_err_irq_ctrl_tb_top;

  localparam int NP = 4;
  localparam int IW = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [11:0]       reg_addr = '0;
  logic [63:0]       reg_wdata = '0;
  logic [NP-1:0]     sf_ce = '0, sf_ue = '0, ro_ce = '0, ro_ue = '0;
  logic [NP-1:0]     ro_fail = '0, asm_dead = '0;
  logic [63:0]       rdata;
  logic [NP*IW-1:0]  sf_inj, ro_inj;
  logic              irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;   // 50 MHz

  txp_err_irq_ctrl #(.NUM_PORTS(NP), .ADDR_W(12)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .reg_wr_i (reg_wr), .reg_addr_i (reg_addr), .reg_wdata_i (reg_wdata),
    .reg_rdata_o (rdata),
    .sf_ce_i (sf_ce), .sf_ue_i (sf_ue), .ro_ce_i (ro_ce), .ro_ue_i (ro_ue),
    .ro_fail_i (ro_fail), .asm_dead_i (asm_dead),
    .sf_inj_o (sf_inj), .ro_inj_o (ro_inj), .irq_o (irq)
  );

  // ---------------- reference model ----------------
  bit [63:0] m_stat, m_mask;
  bit [63:0] m_sfecc [NP];
  bit [63:0] m_roecc [NP];
  bit [17:0] m_sfinj [NP];
  bit [17:0] m_roinj [NP];
  bit        m_irq;

  function automatic bit [63:0] lanes();
    bit [63:0] r = '0;
    for (int p = 0; p < NP; p++) r |= 64'h3f << (8*p);
    return r;
  endfunction

  function automatic int pbase(int p);
    return 'h100 + 'h100*p;
  endfunction

  task automatic m_reset();
    m_stat = '0; m_mask = lanes(); m_irq = 1'b0;
    for (int p = 0; p < NP; p++) begin
      m_sfecc[p] = '0; m_roecc[p] = '0; m_sfinj[p] = '0; m_roinj[p] = '0;
    end
  endtask

  task automatic m_step();
    bit nirq;
    nirq = |(m_stat & ~m_mask);
    if (reg_wr) begin
      if (reg_addr == 12'h000) m_stat &= ~(reg_wdata & lanes());
      if (reg_addr == 12'h008) m_mask = reg_wdata & lanes();
      for (int p = 0; p < NP; p++) begin
        if (reg_addr == pbase(p)      && reg_wdata[31]) m_sfecc[p] = '0;
        if (reg_addr == pbase(p) + 8  && reg_wdata[31]) m_roecc[p] = '0;
        if (reg_addr == pbase(p) + 16) m_sfinj[p] = reg_wdata[17:0];
        if (reg_addr == pbase(p) + 24) m_roinj[p] = reg_wdata[17:0];
      end
    end
    for (int p = 0; p < NP; p++) begin
      m_stat |= 64'({asm_dead[p], ro_fail[p], ro_ue[p], ro_ce[p], sf_ue[p], sf_ce[p]}) << (8*p);
      if (sf_ce[p]) m_sfecc[p][17] = 1'b1;
      if (sf_ue[p]) m_sfecc[p][16] = 1'b1;
      if (ro_ce[p]) m_roecc[p][17] = 1'b1;
      if (ro_ue[p]) m_roecc[p][16] = 1'b1;
    end
    m_irq = nirq;
  endtask

  function automatic bit [63:0] exp_rd(logic [11:0] a);
    if (a == 12'h000) return m_stat;
    if (a == 12'h008) return m_mask;
    for (int p = 0; p < NP; p++) begin
      if (a == pbase(p))      return m_sfecc[p];
      if (a == pbase(p) + 8)  return m_roecc[p];
      if (a == pbase(p) + 16) return 64'(m_sfinj[p]);
      if (a == pbase(p) + 24) return 64'(m_roinj[p]);
    end
    return '0;
  endfunction

  task automatic compare();
    bit [NP*IW-1:0] esf, ero;
    for (int p = 0; p < NP; p++) begin
      esf[p*IW +: IW] = m_sfinj[p];
      ero[p*IW +: IW] = m_roinj[p];
    end
    checks++;
    if (rdata !== exp_rd(reg_addr)) begin
      errors++;
      $display("FAIL %s rdata @%h actual %h expected %h", cur_req, reg_addr, rdata, exp_rd(reg_addr));
    end
    checks++;
    if (irq !== m_irq) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", cur_req, irq, m_irq);
    end
    checks++;
    if (sf_inj !== esf || ro_inj !== ero) begin
      errors++;
      $display("FAIL %s inject actual %h/%h expected %h/%h", cur_req, sf_inj, ro_inj, esf, ero);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    m_step();
    @(negedge clk);
    compare();
  endtask

  task automatic rd(logic [11:0] a);
    reg_wr = 1'b0; reg_addr = a; cycle();
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; cycle();
    reg_wr = 1'b0;
  endtask

  task automatic clr_evt();
    sf_ce = '0; sf_ue = '0; ro_ce = '0; ro_ue = '0; ro_fail = '0; asm_dead = '0;
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state across every register
    cur_req = "R1";
    rd(12'h000); rd(12'h008);
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < 4; s++) rd(12'(pbase(p) + 8*s));

    // R3 masked events raise no interrupt
    cur_req = "R3";
    sf_ce = 4'hF; reg_addr = 12'h000; cycle(); clr_evt();
    rd(12'h000); rd(12'h000);
    wr(12'h008, 64'hFFFF_FFFF_FFFF_FFFF); rd(12'h008);

    // R3/R6 read-modify-write unmask ports 0 and 2
    cur_req = "R6";
    rd(12'h008); v = rdata;
    wr(12'h008, v & ~(64'h3f) & ~(64'h3f << 16));
    rd(12'h000); rd(12'h008); rd(12'h000);

    // R2 each source with its own port pattern
    cur_req = "R2";
    sf_ue = 4'b0100;    reg_addr = 12'h000; cycle(); clr_evt();
    ro_ce = 4'b0010;    cycle(); clr_evt();
    ro_ue = 4'b1001;    cycle(); clr_evt();
    ro_fail = 4'b1000;  cycle(); clr_evt();
    asm_dead = 4'b0110; cycle(); clr_evt();
    rd(12'h000);

    // R4 clear one port lane only, zero write harmless
    cur_req = "R4";
    wr(12'h000, 64'h3f << 8); rd(12'h000);
    wr(12'h000, 64'h0);       rd(12'h000);
    wr(12'h000, 64'h1);       rd(12'h000); rd(12'h000);

    // R5 event during clear of the same lane
    cur_req = "R5";
    sf_ue = 4'b0100;
    wr(12'h000, 64'h3f << 16); clr_evt();
    rd(12'h000); rd(12'h000);

    // R6 mask everything, then clear all status
    cur_req = "R6";
    wr(12'h008, 64'hFFFF_FFFF_FFFF_FFFF); rd(12'h000); rd(12'h000);
    wr(12'h008, 64'h0); rd(12'h000); rd(12'h000);
    wr(12'h000, 64'hFFFF_FFFF_FFFF_FFFF); rd(12'h000); rd(12'h000);
    sf_ce = 4'b1000; cycle(); clr_evt(); rd(12'h000); rd(12'h000);

    // R7 ECC register latching, writes without bit 31 ignored
    cur_req = "R7";
    for (int p = 0; p < NP; p++) begin rd(12'(pbase(p))); rd(12'(pbase(p) + 8)); end
    wr(12'h100, 64'hFFFF_FFFF_7FFF_FFFF); rd(12'h100);
    wr(12'h308, 64'h0000_0000_7FFF_FFFF); rd(12'h308);

    // R8 whole-register wipe, and event during wipe
    cur_req = "R8";
    wr(12'h100, 64'h8000_0000); rd(12'h100);
    ro_ce = 4'b0001;
    wr(12'h108, 64'h8000_0000); clr_evt(); rd(12'h108);
    for (int p = 0; p < NP; p++) wr(12'(pbase(p) + 8), 64'h8000_0000);
    rd(12'h108); rd(12'h208); rd(12'h408);

    // R9 injection words
    cur_req = "R9";
    wr(12'h110, 64'hFFFF_FFFF_FFFF_FFFF); rd(12'h110);
    wr(12'h418, 64'h0000_0000_0002_5555); rd(12'h418);
    wr(12'h218, 64'h1_0000_0001_2345);    rd(12'h218);

    // R10 undecoded addresses
    cur_req = "R10";
    wr(12'h104, 64'hFFFF_FFFF_FFFF_FFFF); rd(12'h104); rd(12'h100);
    wr(12'h500, 64'hFFFF_FFFF_FFFF_FFFF); rd(12'h500);
    wr(12'h010, 64'hFFFF_FFFF_FFFF_FFFF); rd(12'h010); rd(12'h008);
    wr(12'h120, 64'hFFFF_FFFF_FFFF_FFFF); rd(12'h120); rd(12'hFF8);

    // R11 read follows address with no latency
    cur_req = "R11";
    wr(12'h310, 64'h3_0F0F);
    reg_addr = 12'h310; #1;
    checks++;
    if (rdata !== 64'h3_0F0F) begin
      errors++;
      $display("FAIL R11 rdata actual %h expected %h", rdata, 64'h3_0F0F);
    end
    reg_addr = 12'h008; #1;
    checks++;
    if (rdata !== exp_rd(12'h008)) begin
      errors++;
      $display("FAIL R11 rdata actual %h expected %h", rdata, exp_rd(12'h008));
    end
    rd(12'h310);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule